// File: doc/BRIEF.md
# DMA Channel Burst/Transfer Sequencer

This block sequences one DMA channel as two nested loops. A peripheral trigger lets the channel request the bus. Once the grant arrives, the channel moves one 16-bit word per cycle until the burst is complete. A second counter tracks how many bursts are left in the transfer. The block emits a per-word move strobe for the datapath, plus pulses for burst complete and transfer complete. A single interrupt per transfer can be placed at the start of the transfer or at its end.

In the default mode, each trigger buys exactly one burst, and the bus is released after it. In one-shot mode, a single trigger runs all the remaining bursts back to back while holding the bus. Sizes are programmed as count minus one. The configuration inputs act as a shadow set. They are copied into working registers only when a new transfer begins.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, bus_req_o, word_mv_o, burst_done_o, xfer_done_o and irq_o are all 0.
- R2: After a grant, a burst asserts word_mv_o for exactly cfg_burst_m1_i+1 consecutive cycles. burst_done_o is high only in the cycle of its last word.
- R3: A transfer consists of cfg_xfer_m1_i+1 bursts. xfer_done_o pulses for one cycle together with the last word of the last burst. The channel then drops bus_req_o and stays idle until a new trigger.
- R4: With cfg_oneshot_i=0, bus_req_o is 0 in the cycle after every burst that is not the last one, even when a trigger is already pending.
- R5: With cfg_oneshot_i=1, one trigger runs the whole transfer. bus_req_o stays high throughout, and word_mv_o stays high from the first word to the last.
- R6: Triggers that arrive while the channel is requesting or moving are held as a single pending flag. Several of them yield exactly one further burst. A trigger sampled in the same cycle as xfer_done_o starts the next transfer.
- R7: With cfg_irq_en_i=1, irq_o pulses exactly once per transfer. With cfg_irq_end_i=0, the pulse comes in the cycle the transfer leaves idle, before any word moves. With cfg_irq_end_i=1, it coincides with xfer_done_o. With cfg_irq_en_i=0, irq_o stays 0.
- R8: All cfg_* inputs are sampled only when a transfer starts. Changing them mid-transfer has no effect on that transfer.
- R9: word_mv_o is high only while bus_req_o is high, and only after bus_gnt_i has been seen with the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Peripheral trigger, one event per high cycle |
| cfg_burst_m1_i | input | 5 | Words per burst minus one |
| cfg_xfer_m1_i | input | 16 | Bursts per transfer minus one |
| cfg_oneshot_i | input | 1 | 1: whole transfer on one trigger |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cfg_irq_end_i | input | 1 | 0: interrupt at start, 1: at end |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request, held for the burst |
| word_mv_o | output | 1 | Move one word this cycle |
| burst_done_o | output | 1 | Last word of a burst |
| xfer_done_o | output | 1 | Last word of the transfer |
| irq_o | output | 1 | Transfer interrupt pulse |

## Verification
Two events can fall in the same cycle: a new trigger being latched, and the pending flag being consumed or the transfer completing. This is provoked in two ways. Extra triggers are fired while the request waits for a deliberately delayed grant. A trigger is also driven in exactly the cycle where xfer_done_o is seen. In the first case, the bench requires exactly one extra burst and then a silent, released bus. In the second, it requires that the next transfer starts with the newly programmed configuration and delivers the full word and burst counts. Random transfers in both modes also scramble the configuration in mid-flight, and the totals are judged against counts computed from the values programmed at start.

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int BW = 5,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [BW-1:0] cfg_burst_m1_i,
  input  logic [XW-1:0] cfg_xfer_m1_i,
  input  logic          cfg_oneshot_i,
  input  logic          cfg_irq_en_i,
  input  logic          cfg_irq_end_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic          word_mv_o,
  output logic          burst_done_o,
  output logic          xfer_done_o,
  output logic          irq_o
);
  typedef enum logic [1:0] {IDLE, WAIT, REQ, MOVE} st_t;

  st_t           st_q;
  logic          pend_q, os_q, ien_q, iend_q;
  logic [BW-1:0] blen_q, wcnt_q;
  logic [XW-1:0] left_q;

  wire start     = pend_q && st_q == IDLE;
  wire consume   = pend_q && (st_q == IDLE || st_q == WAIT);
  wire last_word = st_q == MOVE && wcnt_q == '0;
  wire last_bst  = left_q == '0;

  assign bus_req_o    = st_q == REQ || st_q == MOVE;
  assign word_mv_o    = st_q == MOVE;
  assign burst_done_o = last_word;
  assign xfer_done_o  = last_word && last_bst;
  assign irq_o        = (start && cfg_irq_en_i && !cfg_irq_end_i)
                      || (xfer_done_o && ien_q && iend_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= trig_i || (pend_q && !consume);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      os_q   <= 1'b0;
      ien_q  <= 1'b0;
      iend_q <= 1'b0;
      blen_q <= '0;
      wcnt_q <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        IDLE: if (start) begin
          blen_q <= cfg_burst_m1_i;
          left_q <= cfg_xfer_m1_i;
          os_q   <= cfg_oneshot_i;
          ien_q  <= cfg_irq_en_i;
          iend_q <= cfg_irq_end_i;
          st_q   <= REQ;
        end
        WAIT: if (pend_q) st_q <= REQ;
        REQ: if (bus_gnt_i) begin
          wcnt_q <= blen_q;
          st_q   <= MOVE;
        end
        MOVE: begin
          if (wcnt_q != '0) wcnt_q <= wcnt_q - 1'b1;
          else if (last_bst) st_q <= IDLE;
          else begin
            left_q <= left_q - 1'b1;
            if (os_q) wcnt_q <= blen_q;
            else      st_q   <= WAIT;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end
endmodule

module dma_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req_o,
  input logic word_mv_o,
  input logic burst_done_o,
  input logic xfer_done_o,
  input logic irq_o,
  input logic os_q
);
  // R9
  word_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_mv_o |-> bus_req_o);
  // R2
  burst_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_o |-> word_mv_o);
  // R3
  done_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> burst_done_o);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !bus_req_o);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done_o && !xfer_done_o && !os_q) |=> !bus_req_o);
  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done_o && !xfer_done_o && os_q) |=> word_mv_o);
  // R7
  irq_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && bus_req_o) |-> xfer_done_o);
endmodule

bind dma_burst_seq dma_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .word_mv_o(word_mv_o),
  .burst_done_o(burst_done_o), .xfer_done_o(xfer_done_o), .irq_o(irq_o),
  .os_q(os_q)
);

// File: tb/tb_dma_burst_seq.sv
module tb_dma_burst_seq;
  logic clk = 0, rst_n = 0, trig = 0, gnt = 0;
  logic [4:0] cb = 0;
  logic [15:0] cx = 0;
  logic cos = 0, cen = 0, cend = 0;
  logic req, wmv, bdone, xdone, irq;

  dma_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .cfg_burst_m1_i(cb),
    .cfg_xfer_m1_i(cx), .cfg_oneshot_i(cos), .cfg_irq_en_i(cen),
    .cfg_irq_end_i(cend), .bus_gnt_i(gnt), .bus_req_o(req),
    .word_mv_o(wmv), .burst_done_o(bdone), .xfer_done_o(xdone), .irq_o(irq)
  );

  always #10 clk = ~clk;

  int vec = 0, bad = 0;
  int e_b, e_x; bit e_en, e_end;
  int words, bursts, wib, irqs, rels;
  bit done_f, prev_req, prev_done, started;
  int age, lat;

  function automatic int exp_words(int b, int x); return (b + 1) * (x + 1); endfunction

  task automatic chk(bit ok, string req_tag, int act, int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (req) begin
      age <= age + 1;
      gnt <= (age + 1 >= lat);
    end else begin
      age <= 0; gnt <= 0; lat <= 4 + int'($urandom % 4);
    end
    if (wmv) begin words++; wib++; end
    if (bdone) begin
      chk(wib == e_b + 1, "R2", wib, e_b + 1);
      bursts++; wib = 0;
    end else if (!wmv && wib != 0) chk(0, "R2", wib, e_b + 1);
    if (irq) begin
      irqs++;
      chk(e_en, "R7", 1, 0);
      if (e_end) chk(xdone, "R7", xdone, 1);
      else chk(words == 0 && !xdone, "R7", words, 0);
    end
    if (prev_req && !req && !prev_done) rels++;
    if (xdone) done_f = 1;
    prev_req = req; prev_done = xdone;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); #1; endtask

  task automatic pulse(); trig = 1; cyc(1); trig = 0; endtask

  task automatic run(int b, int x, bit os, bit en, bit ie, bit chained, bit chain_next);
    cb = 5'(b); cx = 16'(x); cos = os; cen = en; cend = ie;
    e_b = b; e_x = x; e_en = en; e_end = ie;
    words = 0; bursts = 0; wib = 0; irqs = 0; rels = 0; done_f = 0;
    if (!chained) pulse(); else begin cyc(1); trig = 0; end
    while (words == 0) cyc(1);
    cb = 5'($urandom); cx = 16'($urandom); cos = 1'($urandom);  // R8 scramble
    cen = 1'($urandom); cend = 1'($urandom);
    if (os) begin
      while (!done_f) cyc(1);
    end else begin
      while (!done_f) begin
        int b0 = bursts;
        if (bursts != 0) pulse();
        if (e_x + 1 - b0 >= 2 && bursts != 0) begin
          while (!req) cyc(1);
          pulse(); pulse(); pulse();
          while (bursts < b0 + 2 && !done_f) cyc(1);
          if (!done_f) begin
            cyc(8);
            // R6: three triggers collapsed into one burst
            chk(bursts == b0 + 2 && !req, "R6", bursts, b0 + 2);
          end
        end else
          while (bursts == b0 && !done_f) cyc(1);
      end
    end
    if (chain_next) trig = 1;
    chk(words == exp_words(b, x), "R3", words, exp_words(b, x));
    chk(bursts == x + 1, "R3", bursts, x + 1);
    chk(irqs == (en ? 1 : 0), "R7", irqs, en ? 1 : 0);
    // R4 / R5 releases between bursts
    chk(rels == (os ? 0 : x), os ? "R5" : "R4", rels, os ? 0 : x);
    chk(words == exp_words(b, x), "R8", words, exp_words(b, x));
    if (!chain_next) begin
      cyc(5);
      chk(!req && !wmv, "R3", req, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    lat = 4; age = 0;
    cyc(2);
    // R1
    chk(!req && !wmv && !bdone && !xdone && !irq, "R1",
        {req, wmv, bdone, xdone, irq}, 0);
    rst_n = 1;
    cyc(3);
    chk(!req && !wmv, "R1", req, 0);
    run(0, 0, 0, 1, 0, 0, 0);
    run(31, 0, 1, 1, 1, 0, 0);
    run(0, 300, 1, 1, 1, 0, 0);
    run(3, 4, 0, 0, 0, 0, 0);
    run(2, 3, 1, 1, 0, 0, 1);   // R6: trigger in the done cycle
    run(5, 2, 0, 1, 1, 1, 0);
    run(1, 6, 0, 1, 0, 0, 0);
    for (int i = 0; i < 24; i++)
      run(int'($urandom % 32), int'($urandom % 6), 1'($urandom), 1'($urandom),
          1'($urandom), 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule